// File: doc/BRIEF.md
# Timer Interrupt Status Latch

This block captures events from two timer outputs and holds each one as a pending flag until the CPU acknowledges it. Each timer output idles high and signals an event with a low strobe one timer clock long. The flag is set on the rising edge that ends the strobe. The timer outputs come from another clock domain. Each one passes through a two-stage synchroniser, and a rising-edge detector then runs in the system clock domain. Each flag is a small two-state machine with the states `FLAG_CLEAR` and `FLAG_PENDING`. The transition `EV_SET` (a detected rising edge) moves the flag from `FLAG_CLEAR` to `FLAG_PENDING`. The transition `EV_ACK` (a clear write) moves it back to `FLAG_CLEAR`. In any state, a set in the same cycle as a clear keeps the flag in `FLAG_PENDING`.

While either flag is pending, the block pulls an active-low interrupt request low. Software reads both flags through a status port that is selected by an active-low chip-select together with an active-low read strobe. It acknowledges one flag at a time by writing a 0 to that flag's bit through the same chip-select with the active-low write strobe.

Top module: `tmr_irq_latch`

## Requirements
- R1: The block holds two independent flags. Channel 0 (input `tmr0_i`) maps to data bit 0, and channel 1 (input `tmr1_i`) maps to data bit 1. An event on one channel never changes the other channel's flag.
- R2: A low-to-high transition of a timer input sets its flag. Let k be the first rising clock edge that samples the input high. The flag is 1 after edge k+2.
- R3: A high-to-low transition of a timer input does not set its flag, and neither does a constant level, high or low, on that input.
- R4: While `stat_cs_n` and `rd_n` are both 0, `rdata_o[1:0]` shows the flags (bit 0 is channel 0, bit 1 is channel 1), and `rdata_o[7:2]` is 0. The read path is combinational.
- R5: `irq_n` is 0 exactly when at least one flag is 1, and it changes in the same cycle as the flags.
- R6: On a clock edge where `stat_cs_n` and `wr_n` are both 0, every flag whose `wdata_i` bit is 0 is cleared. A flag whose `wdata_i` bit is 1 keeps its value.
- R7: If a set event and a clear write hit the same flag on the same clock edge, the flag ends at 1.
- R8: When the port is not being read, `rdata_o` is 0. A write strobe with `stat_cs_n` high changes no flag.
- R9: After reset both flags are 0 and `irq_n` is 1. The synchronisers reset to the idle-high level, so releasing reset while the timer inputs are high sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr0_i | input | 1 | Timer channel 0 output (asynchronous, idles high) |
| tmr1_i | input | 1 | Timer channel 1 output (asynchronous, idles high) |
| stat_cs_n | input | 1 | Active-low status port select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| wdata_i | input | 2 | Write data; a 0 in a bit acknowledges that flag |
| rdata_o | output | 8 | Status read data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach is a set and a clear that land on the same clock edge. The edge detector sits behind the synchroniser, so the set occurs two edges after the timer input is first sampled high. The stimulus therefore ends a strobe and then counts two falling edges before it drives the clearing write, so that both arrive at the same edge. A behavioural reference model tracks the delayed input history and the flags on every clock. A cycle that misses by one would be reported as a mismatch.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
    typedef enum logic [0:0] {
        FLAG_CLEAR   = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_t;
endpackage

// File: rtl/tirq_edge.sv
module tirq_edge #(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{IDLE}};
            prev_q  <= IDLE;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/tirq_flag.sv
module tirq_flag
    import tirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    flag_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR:   if (set_i) state_d = FLAG_PENDING;
            FLAG_PENDING: if (clr_i && !set_i) state_d = FLAG_CLEAR;
            default:      state_d = FLAG_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        pend_o = (state_q == FLAG_PENDING);
    end
endmodule

// File: rtl/tmr_irq_latch.sv
module tmr_irq_latch #(
    parameter int NCH         = 2,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tmr0_i,
    input  logic          tmr1_i,
    input  logic          stat_cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [NCH-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          irq_n
);
    localparam int PAD = DW - NCH;

    logic [NCH-1:0] tmr_w;
    logic [NCH-1:0] rise_w;
    logic [NCH-1:0] flag_q;
    logic           wr_en;
    logic           rd_en;

    assign tmr_w = {tmr1_i, tmr0_i};
    assign wr_en = ~stat_cs_n & ~wr_n;
    assign rd_en = ~stat_cs_n & ~rd_n;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        tirq_edge #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) edge_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .async_i(tmr_w[c]),
            .rise_o (rise_w[c])
        );
        tirq_flag flag_i (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (rise_w[c]),
            .clr_i (wr_en & ~wdata_i[c]),
            .pend_o(flag_q[c])
        );
    end

    always_comb begin
        rdata_o = '0;
        if (rd_en) rdata_o = {{PAD{1'b0}}, flag_q};
    end

    assign irq_n = ~|flag_q;
endmodule

// File: rtl/tirq_checker.sv
module tirq_checker #(
    parameter int NCH = 2,
    parameter int DW  = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           stat_cs_n,
    input logic           rd_n,
    input logic           wr_n,
    input logic [NCH-1:0] wdata_i,
    input logic [DW-1:0]  rdata_o,
    input logic           irq_n,
    input logic [NCH-1:0] flags,
    input logic [NCH-1:0] rise
);
    a_r5_irq_tracks_flags: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == (flags == '0));

    a_r4_read_shows_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_cs_n && !rd_n) |-> (rdata_o == DW'(flags)));

    a_r8_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_cs_n || rd_n) |-> (rdata_o == '0));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        a_r2_set_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[c]) |-> $past(rise[c]));
        a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            rise[c] |=> flags[c]);
        a_r6_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags[c]) |-> $past(!stat_cs_n && !wr_n && !wdata_i[c]));
        a_r6_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[c] && wdata_i[c]) |=> flags[c]);
    end
endmodule

bind tmr_irq_latch tirq_checker #(.NCH(NCH), .DW(DW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .stat_cs_n(stat_cs_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .irq_n    (irq_n),
    .flags    (flag_q),
    .rise     (rise_w)
);

// File: tb/tmr_irq_latch_tb_top.sv
`timescale 1ns/1ps
module tmr_irq_latch_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tmr0_i = 1'b1, tmr1_i = 1'b1;
    logic       stat_cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] wdata_i = 2'b11;
    logic [7:0] rdata_o;
    logic       irq_n;

    int total = 0;
    int bad   = 0;

    tmr_irq_latch dut_i (
        .clk(clk), .rst_n(rst_n), .tmr0_i(tmr0_i), .tmr1_i(tmr1_i),
        .stat_cs_n(stat_cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_n(irq_n)
    );

    always #5 clk = ~clk;

    // behavioural reference: per channel, history of sampled inputs (newest first)
    bit hist0[$] = '{1, 1, 1};
    bit hist1[$] = '{1, 1, 1};
    bit mflag[2] = '{0, 0};

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit r0, r1, wr;
        if (!rst_n) begin
            hist0 = '{1, 1, 1};
            hist1 = '{1, 1, 1};
            mflag = '{0, 0};
        end else begin
            r0 = hist0[1] & ~hist0[2];
            r1 = hist1[1] & ~hist1[2];
            wr = !stat_cs_n && !wr_n;
            if (r0) mflag[0] = 1; else if (wr && !wdata_i[0]) mflag[0] = 0;
            if (r1) mflag[1] = 1; else if (wr && !wdata_i[1]) mflag[1] = 0;
            hist0.push_front(tmr0_i); void'(hist0.pop_back());
            hist1.push_front(tmr1_i); void'(hist1.pop_back());
        end
        #3;
        check("R5 irq model", irq_n, !(mflag[0] || mflag[1]));
        check("R4/R8 data model", rdata_o,
              (!stat_cs_n && !rd_n) ? {6'd0, mflag[1], mflag[0]} : 8'd0);
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic read_chk(input string req, input logic [7:0] exp);
        @(negedge clk);
        stat_cs_n = 1'b0; rd_n = 1'b0;
        #2;
        check(req, rdata_o, exp);
        @(negedge clk);
        stat_cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic write_port(input logic cs_n, input logic [1:0] d);
        @(negedge clk);
        stat_cs_n = cs_n; wr_n = 1'b0; wdata_i = d;
        @(negedge clk);
        stat_cs_n = 1'b1; wr_n = 1'b1; wdata_i = 2'b11;
    endtask

    task automatic strobe(input int ch);
        @(negedge clk);
        if (ch == 0) tmr0_i = 1'b0; else tmr1_i = 1'b0;
        @(negedge clk);
        if (ch == 0) tmr0_i = 1'b1; else tmr1_i = 1'b1;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(4);
        // R9: reset state with inputs idle high
        check("R9 irq after reset", irq_n, 1);
        read_chk("R9 flags after reset", 8'h00);

        // R2 latency and R1 mapping
        strobe(0);
        @(negedge clk); #1; check("R2 not yet set after k", irq_n, 1);
        @(negedge clk); #1; check("R2 not yet set after k+1", irq_n, 1);
        @(negedge clk); #1; check("R2 set after k+2", irq_n, 0);
        read_chk("R1 channel 0 on bit 0", 8'h01);

        // R3: falling edge and long low do not set
        @(negedge clk); tmr1_i = 1'b0;
        idle(8);
        read_chk("R3 falling edge no set", 8'h01);
        @(negedge clk); tmr1_i = 1'b1;
        idle(4);
        read_chk("R1 both flags", 8'h03);

        // R6 clear and keep
        write_port(1'b0, 2'b10);
        read_chk("R6 clear bit 0 only", 8'h02);
        check("R5 irq still low", irq_n, 0);
        write_port(1'b0, 2'b11);
        read_chk("R6 writing 1 keeps", 8'h02);

        // R8: write without select ignored, bus zero when not reading
        write_port(1'b1, 2'b00);
        read_chk("R8 write without cs ignored", 8'h02);
        @(negedge clk); #1; check("R8 bus idle zero", rdata_o, 0);

        write_port(1'b0, 2'b01);
        read_chk("R6 clear bit 1", 8'h00);
        check("R5 irq released", irq_n, 1);

        // R7: set and clear on the same edge
        strobe(0);
        @(negedge clk);
        @(negedge clk);
        stat_cs_n = 1'b0; wr_n = 1'b0; wdata_i = 2'b10;
        @(negedge clk);
        stat_cs_n = 1'b1; wr_n = 1'b1; wdata_i = 2'b11;
        read_chk("R7 set wins over clear", 8'h01);

        // R1 independence: channel 1 event leaves channel 0
        write_port(1'b0, 2'b10);
        strobe(1);
        idle(4);
        read_chk("R1 channel 1 alone", 8'h02);
        write_port(1'b0, 2'b00);
        read_chk("R6 clear both", 8'h00);

        // R9: reset with flags set, then release with inputs high
        strobe(0);
        idle(4);
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        @(negedge clk); rst_n = 1'b1;
        idle(5);
        read_chk("R9 no set on release", 8'h00);

        idle(3);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule